// File: doc/BRIEF.md
# Single-Slope Capacitor ADC Sequencer

This block sequences a counting (single-slope) conversion. It drives a switchable current source into a reference capacitor and counts sense-clock ticks until a comparator watching that capacitor changes state. A start pulse launches a run. The run uses one of three mode codes, and the code is captured when the run starts.

- The full-reference mode discharges the capacitor and then counts the charge time up to the threshold. This count is kept as time A.
- The half-reference mode first sinks current for A/2 ticks and then counts the time to return to the threshold.
- The input mode first opens an aperture to sample the input. It then checks the comparator to decide whether the source must sink or source, and counts the time to reach the threshold.

When a run ends, the block presents the count, the current direction it used, overflow and abort flags, and a one-cycle result-ready pulse. The analog capacitor, current source and comparator are outside the block. The block sees them only through its control outputs and the comparator input.

Top module: `ramp_adc_seq`

## Requirements
- R1: After reset, all control outputs are low, the result is 0, the polarity and both flags are 0, and resultReady is low.
- R2: A start is accepted only while idle and only with a mode code of 1, 2 or 3. Code 0 (off) is ignored and leaves every output unchanged. The mode code is captured at start, so changing modeSel during a run has no effect on that run.
- R3: In mode 1, dischargeSw is high for exactly apertureTime+1 senseTick pulses. After that, srcEn is high with srcSink low (the source charges the capacitor).
- R4: Counting begins when the source starts its counting phase. Every senseTick during counting adds one. The first clock on which cmpOut differs from its level at the start of counting ends the run. The result then equals the ticks counted, and resultReady is high for exactly one cycle, in the cycle after that clock.
- R5: A mode-1 result is kept as time A. Mode 2 sinks (srcEn and srcSink both high) for A>>1 senseTick pulses and then sources and counts as in R4. If A>>1 is 0, the sink phase is skipped.
- R6: In mode 3, sampleSw is high for apertureTime+1 senseTick pulses. One cycle later, cmpOut is sampled. A sampled 1 (input above the threshold) selects sink and a sampled 0 selects source, and counting follows as in R4. Mode 1 never sinks.
- R7: The polarity output is 1 when the counting phase sank current and 0 when it sourced current. It holds that value alongside the result.
- R8: If a senseTick arrives while the count is at its all-ones value and no comparator change occurs, the counter wraps. The run then ends with result 0, overflowFlag set to 1 and a resultReady pulse.
- R9: A seqAbort during a run returns the block to idle in the next cycle, with all switch and source controls low. It sets abortFlag, gives no resultReady and leaves the result unchanged. A seqAbort while idle has no effect.
- R10: An accepted start clears overflowFlag and abortFlag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| modeSel | input | 2 | Mode code: 0 off, 1 full-reference count, 2 half-reference count, 3 input count |
| apertureTime | input | AP_W | Length of the discharge or aperture step, minus one, in sense ticks |
| senseTick | input | 1 | One-cycle strobe, once per sense-clock period |
| cmpOut | input | 1 | Comparator output (1 = capacitor above the threshold) |
| seqStart | input | 1 | Start pulse, issued when the main sequencer enters its normal-sample state |
| seqAbort | input | 1 | Abort pulse |
| srcEn | output | 1 | Current source enable |
| srcSink | output | 1 | Current source direction (1 sink, 0 source) |
| dischargeSw | output | 1 | Capacitor discharge switch |
| sampleSw | output | 1 | Input aperture switch |
| result | output | CNT_W | Last conversion count |
| polarity | output | 1 | Direction used for the last count (1 sink) |
| overflowFlag | output | 1 | Counter wrapped during the last run |
| abortFlag | output | 1 | Last run was aborted |
| resultReady | output | 1 | One-cycle pulse when the result is valid |

## Verification
A state register stuck in, or leaving early from, the discharge or aperture step shows up at once on dischargeSw or sampleSw, one tick off the expected apertureTime+1. A wrong stored time A shows up in the next half-reference run as a sink phase of the wrong length on srcSink. A counter that misses a tick, or a comparator reference captured at the wrong cycle, gives a wrong result value or a missing resultReady pulse in the cycle right after the comparator edge. A wrongly routed abort or overflow shows up in the flags on the following cycle.

// File: rtl/ramp_adc_pkg.sv
`timescale 1ns/1ps
package ramp_adc_pkg;

  typedef enum logic [1:0] {
    MODE_OFF  = 2'd0,
    MODE_REF  = 2'd1,
    MODE_HALF = 2'd2,
    MODE_VIN  = 2'd3
  } adcMode_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DISCH,
    ST_APER,
    ST_POLDET,
    ST_SINK,
    ST_COUNT
  } seqState_t;

  // strobes from the control FSM to the datapath
  typedef struct packed {
    logic clrFlags;
    logic loadAp;
    logic loadHalf;
    logic phDec;
    logic beginCount;
    logic dirSink;
    logic cntInc;
    logic finishOk;
    logic finishOvf;
    logic storeA;
    logic abortHit;
  } dpStrobe_t;

endpackage

// File: rtl/ramp_adc_dpath.sv
`timescale 1ns/1ps
module ramp_adc_dpath
  import ramp_adc_pkg::*;
#(
  parameter int AP_W  = 8,
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  dpStrobe_t        stb,
  input  logic [AP_W-1:0]  apertureTime,
  input  logic             cmpOut,
  output logic             phZero,
  output logic             phOne,
  output logic             cntMax,
  output logic             halfZero,
  output logic             cmpChanged,
  output logic [CNT_W-1:0] result,
  output logic             polarity,
  output logic             overflowFlag,
  output logic             abortFlag,
  output logic             resultReady
);

  localparam int PH_W = (AP_W > CNT_W) ? AP_W : CNT_W;

  logic [PH_W-1:0]  phaseCnt;
  logic [CNT_W-1:0] convCnt;
  logic [CNT_W-1:0] timeA;
  logic [CNT_W-1:0] halfA;
  logic             cmpRef;

  assign halfA      = timeA >> 1;
  assign halfZero   = (halfA == '0);
  assign phZero     = (phaseCnt == '0);
  assign phOne      = (phaseCnt == PH_W'(1));
  assign cntMax     = &convCnt;
  assign cmpChanged = (cmpOut != cmpRef);

  // phase timer: aperture/discharge length or sink length
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phaseCnt <= '0;
    end else if (stb.loadAp) begin
      phaseCnt <= PH_W'(apertureTime);
    end else if (stb.loadHalf) begin
      phaseCnt <= PH_W'(halfA);
    end else if (stb.phDec) begin
      phaseCnt <= phaseCnt - PH_W'(1);
    end
  end

  // conversion counter and comparator reference
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      convCnt  <= '0;
      cmpRef   <= 1'b0;
      polarity <= 1'b0;
    end else if (stb.beginCount) begin
      convCnt  <= '0;
      cmpRef   <= cmpOut;
      polarity <= stb.dirSink;
    end else if (stb.cntInc) begin
      convCnt  <= convCnt + CNT_W'(1);
    end
  end

  // result, stored time A, flags
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      result       <= '0;
      timeA        <= '0;
      overflowFlag <= 1'b0;
      abortFlag    <= 1'b0;
      resultReady  <= 1'b0;
    end else begin
      resultReady <= stb.finishOk | stb.finishOvf;
      if (stb.clrFlags) begin
        overflowFlag <= 1'b0;
        abortFlag    <= 1'b0;
      end
      if (stb.finishOk) begin
        result <= convCnt;
      end else if (stb.finishOvf) begin
        result       <= '0;
        overflowFlag <= 1'b1;
      end
      if (stb.storeA) begin
        timeA <= stb.finishOk ? convCnt : '0;
      end
      if (stb.abortHit) begin
        abortFlag <= 1'b1;
      end
    end
  end

  a_r4_ready_pulse: assert property (@(posedge clk) disable iff (!rstN)
    resultReady |=> !resultReady);

  a_r8_ovf_zero: assert property (@(posedge clk) disable iff (!rstN)
    (resultReady && overflowFlag) |-> (result == '0));

  a_r9_abort_flag: assert property (@(posedge clk) disable iff (!rstN)
    stb.abortHit |=> (abortFlag && !resultReady && $stable(result)));

  a_r10_flags_clear: assert property (@(posedge clk) disable iff (!rstN)
    stb.clrFlags |=> (!overflowFlag && !abortFlag));

endmodule

// File: rtl/ramp_adc_ctrl.sv
`timescale 1ns/1ps
module ramp_adc_ctrl
  import ramp_adc_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic [1:0] modeSel,
  input  logic       seqStart,
  input  logic       seqAbort,
  input  logic       senseTick,
  input  logic       cmpOut,
  input  logic       phZero,
  input  logic       phOne,
  input  logic       cntMax,
  input  logic       halfZero,
  input  logic       cmpChanged,
  input  logic       polarity,
  output dpStrobe_t  stb,
  output logic       srcEn,
  output logic       srcSink,
  output logic       dischargeSw,
  output logic       sampleSw
);

  seqState_t state, nextState;
  adcMode_t  modeReg;
  logic      busy;

  assign busy = (state != ST_IDLE);

  always_comb begin
    stb       = '0;
    nextState = state;
    if (busy && seqAbort) begin
      nextState    = ST_IDLE;
      stb.abortHit = 1'b1;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (seqStart && (modeSel != MODE_OFF)) begin
            stb.clrFlags = 1'b1;
            case (adcMode_t'(modeSel))
              MODE_REF: begin
                nextState  = ST_DISCH;
                stb.loadAp = 1'b1;
              end
              MODE_VIN: begin
                nextState  = ST_APER;
                stb.loadAp = 1'b1;
              end
              default: begin
                if (halfZero) begin
                  nextState      = ST_COUNT;
                  stb.beginCount = 1'b1;
                end else begin
                  nextState    = ST_SINK;
                  stb.loadHalf = 1'b1;
                end
              end
            endcase
          end
        end
        ST_DISCH, ST_APER: begin
          if (senseTick) begin
            if (phZero) begin
              nextState      = (state == ST_DISCH) ? ST_COUNT : ST_POLDET;
              stb.beginCount = (state == ST_DISCH);
            end else begin
              stb.phDec = 1'b1;
            end
          end
        end
        ST_POLDET: begin
          nextState      = ST_COUNT;
          stb.beginCount = 1'b1;
          stb.dirSink    = cmpOut;
        end
        ST_SINK: begin
          if (senseTick) begin
            if (phOne) begin
              nextState      = ST_COUNT;
              stb.beginCount = 1'b1;
            end else begin
              stb.phDec = 1'b1;
            end
          end
        end
        ST_COUNT: begin
          if (cmpChanged) begin
            nextState    = ST_IDLE;
            stb.finishOk = 1'b1;
            stb.storeA   = (modeReg == MODE_REF);
          end else if (senseTick) begin
            if (cntMax) begin
              nextState     = ST_IDLE;
              stb.finishOvf = 1'b1;
              stb.storeA    = (modeReg == MODE_REF);
            end else begin
              stb.cntInc = 1'b1;
            end
          end
        end
        default: nextState = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      modeReg <= MODE_OFF;
    end else begin
      state <= nextState;
      if (!busy && seqStart && (modeSel != MODE_OFF)) begin
        modeReg <= adcMode_t'(modeSel);
      end
    end
  end

  assign srcEn       = (state == ST_SINK) || (state == ST_COUNT);
  assign srcSink     = (state == ST_SINK) || ((state == ST_COUNT) && polarity);
  assign dischargeSw = (state == ST_DISCH);
  assign sampleSw    = (state == ST_APER);

  a_r3_switch_excl: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({dischargeSw, sampleSw, srcEn}));

  a_r6_ref_never_sinks: assert property (@(posedge clk) disable iff (!rstN)
    srcSink |-> (modeReg != MODE_REF));

  a_r9_abort_idle: assert property (@(posedge clk) disable iff (!rstN)
    (busy && seqAbort) |=> (!srcEn && !dischargeSw && !sampleSw));

  a_r2_off_ignored: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && seqStart && (modeSel == MODE_OFF)) |=> (state == ST_IDLE));

endmodule

// File: rtl/ramp_adc_seq.sv
`timescale 1ns/1ps
module ramp_adc_seq
  import ramp_adc_pkg::*;
#(
  parameter int AP_W  = 8,
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [1:0]       modeSel,
  input  logic [AP_W-1:0]  apertureTime,
  input  logic             senseTick,
  input  logic             cmpOut,
  input  logic             seqStart,
  input  logic             seqAbort,
  output logic             srcEn,
  output logic             srcSink,
  output logic             dischargeSw,
  output logic             sampleSw,
  output logic [CNT_W-1:0] result,
  output logic             polarity,
  output logic             overflowFlag,
  output logic             abortFlag,
  output logic             resultReady
);

  dpStrobe_t stb;
  logic phZero, phOne, cntMax, halfZero, cmpChanged;

  ramp_adc_ctrl u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .modeSel     (modeSel),
    .seqStart    (seqStart),
    .seqAbort    (seqAbort),
    .senseTick   (senseTick),
    .cmpOut      (cmpOut),
    .phZero      (phZero),
    .phOne       (phOne),
    .cntMax      (cntMax),
    .halfZero    (halfZero),
    .cmpChanged  (cmpChanged),
    .polarity    (polarity),
    .stb         (stb),
    .srcEn       (srcEn),
    .srcSink     (srcSink),
    .dischargeSw (dischargeSw),
    .sampleSw    (sampleSw)
  );

  ramp_adc_dpath #(.AP_W(AP_W), .CNT_W(CNT_W)) u_dpath (
    .clk          (clk),
    .rstN         (rstN),
    .stb          (stb),
    .apertureTime (apertureTime),
    .cmpOut       (cmpOut),
    .phZero       (phZero),
    .phOne        (phOne),
    .cntMax       (cntMax),
    .halfZero     (halfZero),
    .cmpChanged   (cmpChanged),
    .result       (result),
    .polarity     (polarity),
    .overflowFlag (overflowFlag),
    .abortFlag    (abortFlag),
    .resultReady  (resultReady)
  );

endmodule

// File: tb/ramp_adc_seq_bench.sv
`timescale 1ns/1ps
module ramp_adc_seq_bench;

  localparam int AP_W  = 8;
  localparam int CNT_W = 16;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic [1:0]       modeSel = '0;
  logic [AP_W-1:0]  apertureTime = '0;
  logic             senseTick = 1'b0;
  logic             cmpOut = 1'b0;
  logic             seqStart = 1'b0;
  logic             seqAbort = 1'b0;
  logic             srcEn, srcSink, dischargeSw, sampleSw;
  logic [CNT_W-1:0] result;
  logic             polarity, overflowFlag, abortFlag, resultReady;

  int nChecks = 0;
  int nErr = 0;
  int lastA = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  ramp_adc_seq #(.AP_W(AP_W), .CNT_W(CNT_W)) u_ramp_adc_seq (
    .clk(clk), .rstN(rstN), .modeSel(modeSel), .apertureTime(apertureTime),
    .senseTick(senseTick), .cmpOut(cmpOut), .seqStart(seqStart), .seqAbort(seqAbort),
    .srcEn(srcEn), .srcSink(srcSink), .dischargeSw(dischargeSw), .sampleSw(sampleSw),
    .result(result), .polarity(polarity), .overflowFlag(overflowFlag),
    .abortFlag(abortFlag), .resultReady(resultReady)
  );

  // mode[26:25] aperture[24:17] ticks[16:1] cmpStart[0]
  localparam logic [26:0] VEC [8] = '{
    {2'd1, 8'd2, 16'd10, 1'b0},
    {2'd2, 8'd0, 16'd7,  1'b0},
    {2'd3, 8'd1, 16'd4,  1'b1},
    {2'd3, 8'd3, 16'd9,  1'b0},
    {2'd1, 8'd0, 16'd1,  1'b0},
    {2'd2, 8'd0, 16'd3,  1'b0},
    {2'd1, 8'd5, 16'd0,  1'b0},
    {2'd2, 8'd0, 16'd2,  1'b0}
  };

  task automatic chk(input string tag, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nErr++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic pulseTick();
    senseTick = 1'b1;
    @(negedge clk);
    senseTick = 1'b0;
  endtask

  task automatic pulseStart(input int md, input int ap);
    modeSel = md[1:0];
    apertureTime = ap[AP_W-1:0];
    seqStart = 1'b1;
    @(negedge clk);
    seqStart = 1'b0;
  endtask

  task automatic runConv(input int md, input int ap, input int n, input bit cmpIn);
    int k;
    cmpOut = cmpIn;
    pulseStart(md, ap);
    k = 0;
    if (md == 1) begin
      while (dischargeSw && k < 300) begin pulseTick(); k++; end
      chk("R3 discharge ticks", k, ap + 1);
    end else if (md == 3) begin
      while (sampleSw && k < 300) begin pulseTick(); k++; end
      chk("R6 aperture ticks", k, ap + 1);
    end else begin
      while (srcSink && k < 300) begin pulseTick(); k++; end
      chk("R5 sink ticks", k, lastA >> 1);
    end
    @(negedge clk);
    chk("R4 source enabled while counting", int'(srcEn), 1);
    chk((md == 3) ? "R6 direction" : "R3 direction", int'(srcSink), (md == 3) ? int'(cmpIn) : 0);
    repeat (n) pulseTick();
    cmpOut = ~cmpIn;
    @(negedge clk);
    chk("R4 ready pulse", int'(resultReady), 1);
    chk("R4 result", int'(result), n);
    chk("R7 polarity", int'(polarity), (md == 3) ? int'(cmpIn) : 0);
    @(negedge clk);
    chk("R4 ready single cycle", int'(resultReady), 0);
    if (md == 1) lastA = n;
  endtask

  task automatic finishRun();
    $display("Simulation finished: %0d checks, %0d errors", nChecks, nErr);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      nChecks++;
      nErr++;
      $display("FAIL watchdog actual=timeout expected=completion");
      finishRun();
    end
  end

  initial begin
    int saved;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 srcEn", int'(srcEn), 0);
    chk("R1 switches", int'({dischargeSw, sampleSw, srcSink}), 0);
    chk("R1 result", int'(result), 0);
    chk("R1 flags", int'({polarity, overflowFlag, abortFlag, resultReady}), 0);
    rstN = 1'b1;
    @(negedge clk);

    // vector table
    for (int i = 0; i < 8; i++) begin
      runConv(int'(VEC[i][26:25]), int'(VEC[i][24:17]), int'(VEC[i][16:1]), VEC[i][0]);
    end

    // R2: mode 0 start ignored
    saved = int'(result);
    pulseStart(0, 2);
    repeat (3) begin
      chk("R2 off mode idle", int'({srcEn, dischargeSw, sampleSw, resultReady}), 0);
      @(negedge clk);
    end
    chk("R2 off mode result kept", int'(result), saved);

    // R2: mode latched at start
    cmpOut = 1'b0;
    pulseStart(1, 0);
    modeSel = 2'd3;
    chk("R2 latched mode discharge", int'({dischargeSw, sampleSw}), 2);
    pulseTick();
    modeSel = 2'd0;
    repeat (6) pulseTick();
    cmpOut = 1'b1;
    @(negedge clk);
    chk("R2 latched mode result", int'(result), 6);
    lastA = 6;
    runConv(2, 0, 5, 1'b0);

    // R9: abort while idle
    seqAbort = 1'b1;
    @(negedge clk);
    seqAbort = 1'b0;
    @(negedge clk);
    chk("R9 idle abort ignored", int'(abortFlag), 0);

    // R9: abort during count
    saved = int'(result);
    cmpOut = 1'b0;
    pulseStart(1, 1);
    repeat (2) pulseTick();
    chk("R9 counting before abort", int'(srcEn), 1);
    repeat (3) pulseTick();
    seqAbort = 1'b1;
    @(negedge clk);
    seqAbort = 1'b0;
    chk("R9 outputs off", int'({srcEn, srcSink, dischargeSw, sampleSw}), 0);
    chk("R9 abort flag", int'(abortFlag), 1);
    chk("R9 no ready", int'(resultReady), 0);
    chk("R9 result kept", int'(result), saved);
    cmpOut = 1'b1;
    repeat (2) @(negedge clk);
    chk("R9 still no ready", int'(resultReady), 0);

    // R10: start clears abort flag
    pulseStart(3, 0);
    chk("R10 abort cleared", int'(abortFlag), 0);
    pulseTick();
    @(negedge clk);
    cmpOut = 1'b0;
    @(negedge clk);

    // R8: overflow
    cmpOut = 1'b0;
    pulseStart(1, 0);
    pulseTick();
    senseTick = 1'b1;
    repeat (65535) @(negedge clk);
    chk("R8 no early finish", int'(resultReady), 0);
    @(negedge clk);
    senseTick = 1'b0;
    chk("R8 ready on wrap", int'(resultReady), 1);
    chk("R8 overflow flag", int'(overflowFlag), 1);
    chk("R8 wrapped result", int'(result), 0);
    @(negedge clk);
    lastA = 0;

    // R10: start clears overflow; also R5 with stored A of 0
    runConv(2, 0, 4, 1'b0);
    chk("R10 overflow cleared", int'(overflowFlag), 0);

    done = 1'b1;
    finishRun();
  end

endmodule